// File: doc/BRIEF.md
# Pulse Generator Next-Data Buffer

This block keeps the pattern that a pulse generator drives next on eight output bits. The bits form two 4-bit groups: an upper group on bits 7..4 and a lower group on bits 3..0. When the trigger assigned to a group fires, the buffered bits move into the output data register in the same bit positions.

A configuration input chooses between two modes. In shared mode both groups follow one trigger, and the whole byte sits at a single bus address. In split mode each group has its own trigger and its own address. Each nibble address reads back its unused half as all ones. The register bus uses single-cycle write strobes and returns read data combinationally for the address presented.

Top module: `pgen_next_buf`

## Requirements
- R1: After reset, the buffered pattern and `pout` are both 8'h00.
- R2: In shared mode (`trig_shared`=1), address 0 reads the full buffered byte. A write there loads all eight bits from `bus_wdata`.
- R3: In shared mode, address 1 reads 8'hFF and writes to it leave the buffered pattern unchanged.
- R4: In split mode, address 0 holds the upper group. It reads as {upper nibble, 4'b1111}. A write loads only `bus_wdata[7:4]` and leaves the lower group unchanged.
- R5: In split mode, address 1 holds the lower group. It reads as {4'b1111, lower nibble}. A write loads only `bus_wdata[3:0]` and leaves the upper group unchanged.
- R6: In split mode, a pulse on `trig_hi` copies buffered bits 7..4 into `pout[7:4]` on that clock edge. It does not change `pout[3:0]`.
- R7: In split mode, a pulse on `trig_lo` copies buffered bits 3..0 into `pout[3:0]` on that clock edge. It does not change `pout[7:4]`.
- R8: In shared mode, `trig_hi` copies all eight buffered bits into `pout`, and `trig_lo` has no effect.
- R9: When a write and a trigger share a clock edge, `pout` takes the pattern buffered before the write, and the buffer takes the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_shared | input | 1 | 1 = both groups follow `trig_hi`; 0 = each group has its own trigger |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| trig_hi | input | 1 | Transfer pulse for the upper group |
| trig_lo | input | 1 | Transfer pulse for the lower group |
| pout | output | 8 | Output data register |

## Verification
The hardest case to reach is a write and a trigger on the same edge. The output must then show the earlier pattern, and the buffer only shows the new one on the next read. The stimulus table makes a write different from the buffered value in the same cycle as one or both triggers, in both modes. Each row then reads the buffer back, so the old and new values can be told apart. Other rows write the reserved half of a nibble address and shared-mode address 1, and then read the buffer back to show that nothing changed.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
    localparam int unsigned PG_GRP_W  = 4;
    localparam int unsigned PG_DATA_W = 2 * PG_GRP_W;

    typedef struct packed {
        logic [PG_GRP_W-1:0] hi;
        logic [PG_GRP_W-1:0] lo;
    } pg_pair_t;

    typedef enum logic [0:0] {
        PG_ADDR_A = 1'b0,
        PG_ADDR_B = 1'b1
    } pg_addr_e;
endpackage

// File: rtl/pgen_bus_map.sv
module pgen_bus_map
    import pgen_pkg::*;
#(
    parameter int unsigned GRP_W = PG_GRP_W
) (
    input  logic               shared_i,
    input  logic               wr_i,
    input  logic               addr_i,
    input  logic [2*GRP_W-1:0] wdata_i,
    input  logic [2*GRP_W-1:0] buf_i,
    output logic               wr_hi_o,
    output logic               wr_lo_o,
    output logic [2*GRP_W-1:0] rdata_o
);
    localparam int unsigned DW = 2 * GRP_W;

    logic at_a;
    assign at_a = (addr_i == PG_ADDR_A);

    always_comb begin
        wr_hi_o = 1'b0;
        wr_lo_o = 1'b0;
        rdata_o = '1;
        if (shared_i) begin
            if (at_a) begin
                wr_hi_o = wr_i;
                wr_lo_o = wr_i;
                rdata_o = buf_i;
            end
        end else if (at_a) begin
            wr_hi_o = wr_i;
            rdata_o = {buf_i[DW-1:GRP_W], {GRP_W{1'b1}}};
        end else begin
            wr_lo_o = wr_i;
            rdata_o = {{GRP_W{1'b1}}, buf_i[GRP_W-1:0]};
        end
    end
endmodule

// File: rtl/pgen_xfer.sv
module pgen_xfer
    import pgen_pkg::*;
#(
    parameter int unsigned GRP_W = PG_GRP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shared_i,
    input  logic               trig_hi_i,
    input  logic               trig_lo_i,
    input  logic [2*GRP_W-1:0] buf_i,
    output logic [2*GRP_W-1:0] pout_o
);
    localparam int unsigned DW = 2 * GRP_W;

    typedef struct packed {
        logic [GRP_W-1:0] hi;
        logic [GRP_W-1:0] lo;
    } out_t;

    out_t st_d, st_q;
    logic take_hi, take_lo;

    always_comb begin
        take_hi = trig_hi_i;
        take_lo = shared_i ? trig_hi_i : trig_lo_i;
        st_d    = st_q;
        if (take_hi) st_d.hi = buf_i[DW-1:GRP_W];
        if (take_lo) st_d.lo = buf_i[GRP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pout_o = {st_q.hi, st_q.lo};

    assert_split_hi_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shared_i && trig_hi_i && !trig_lo_i) |=>
            (pout_o[DW-1:GRP_W] == $past(buf_i[DW-1:GRP_W])) && $stable(pout_o[GRP_W-1:0]));
    assert_split_lo_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!shared_i && trig_lo_i && !trig_hi_i) |=>
            (pout_o[GRP_W-1:0] == $past(buf_i[GRP_W-1:0])) && $stable(pout_o[DW-1:GRP_W]));
    assert_shared_lo_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_i && trig_lo_i && !trig_hi_i) |=> $stable(pout_o));
    assert_shared_old_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_i && trig_hi_i) |=> (pout_o == $past(buf_i)));
endmodule

// File: rtl/pgen_next_buf.sv
module pgen_next_buf
    import pgen_pkg::*;
#(
    parameter int unsigned GRP_W = PG_GRP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_shared,
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic [2*GRP_W-1:0] bus_wdata,
    output logic [2*GRP_W-1:0] bus_rdata,
    input  logic               trig_hi,
    input  logic               trig_lo,
    output logic [2*GRP_W-1:0] pout
);
    localparam int unsigned DW = 2 * GRP_W;

    typedef struct packed {
        logic [GRP_W-1:0] hi;
        logic [GRP_W-1:0] lo;
    } buf_t;

    buf_t          nb_d, nb_q;
    logic          wr_hi, wr_lo;
    logic [DW-1:0] nb_flat;

    assign nb_flat = {nb_q.hi, nb_q.lo};

    pgen_bus_map #(.GRP_W(GRP_W)) u_map (
        .shared_i (trig_shared),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .buf_i    (nb_flat),
        .wr_hi_o  (wr_hi),
        .wr_lo_o  (wr_lo),
        .rdata_o  (bus_rdata)
    );

    always_comb begin
        nb_d = nb_q;
        if (wr_hi) nb_d.hi = bus_wdata[DW-1:GRP_W];
        if (wr_lo) nb_d.lo = bus_wdata[GRP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nb_q <= '0;
        else        nb_q <= nb_d;
    end

    pgen_xfer #(.GRP_W(GRP_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .shared_i  (trig_shared),
        .trig_hi_i (trig_hi),
        .trig_lo_i (trig_lo),
        .buf_i     (nb_flat),
        .pout_o    (pout)
    );

    assert_shared_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && trig_shared && bus_addr == 1'b0) |=> (nb_flat == $past(bus_wdata)));
    assert_shared_b_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && trig_shared && bus_addr == 1'b1) |=> $stable(nb_flat));
    assert_split_a_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !trig_shared && bus_addr == 1'b0) |=>
            $stable(nb_flat[GRP_W-1:0]) && (nb_flat[DW-1:GRP_W] == $past(bus_wdata[DW-1:GRP_W])));
    assert_split_b_keeps_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !trig_shared && bus_addr == 1'b1) |=>
            $stable(nb_flat[DW-1:GRP_W]) && (nb_flat[GRP_W-1:0] == $past(bus_wdata[GRP_W-1:0])));
    assert_split_a_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_shared && bus_addr == 1'b0) |-> (bus_rdata[GRP_W-1:0] == '1));
    assert_split_b_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_shared && bus_addr == 1'b1) |-> (bus_rdata[DW-1:GRP_W] == '1));
endmodule

// File: tb/tb_pgen_next_buf.sv
module tb_pgen_next_buf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_shared = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       trig_hi = 1'b0;
    logic       trig_lo = 1'b0;
    logic [7:0] pout;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pgen_next_buf dut (
        .clk(clk), .rst_n(rst_n), .trig_shared(trig_shared),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .trig_hi(trig_hi), .trig_lo(trig_lo), .pout(pout)
    );

    // row: shared, wr, addr, wdata, thi, tlo, read addr, expected pout, expected rdata
    localparam int NV = 17;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1,1'b1,1'b0,8'hA5,1'b0,1'b0,1'b0,8'h00,8'hA5}, // R2
        {1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,8'hA5,8'hA5}, // R8
        {1'b1,1'b1,1'b0,8'h3C,1'b1,1'b0,1'b0,8'hA5,8'h3C}, // R9
        {1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,8'h3C,8'h3C}, // R8
        {1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,8'h3C,8'hFF}, // R8 R3
        {1'b0,1'b1,1'b0,8'h9F,1'b0,1'b0,1'b0,8'h3C,8'h9F}, // R4
        {1'b0,1'b1,1'b1,8'h42,1'b0,1'b0,1'b1,8'h3C,8'hF2}, // R5
        {1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h32,8'h9F}, // R7
        {1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,8'h92,8'hF2}, // R6
        {1'b0,1'b1,1'b0,8'h60,1'b0,1'b0,1'b0,8'h92,8'h6F}, // R4
        {1'b0,1'b1,1'b1,8'h07,1'b1,1'b1,1'b1,8'h62,8'hF7}, // R9
        {1'b0,1'b1,1'b0,8'h0F,1'b0,1'b0,1'b0,8'h62,8'h0F}, // R4
        {1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,8'h07,8'h0F}, // R6 R7
        {1'b1,1'b1,1'b1,8'hAA,1'b0,1'b0,1'b0,8'h07,8'h07}, // R3
        {1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,8'h07,8'h07}, // R8
        {1'b1,1'b1,1'b0,8'hE1,1'b0,1'b1,1'b0,8'h07,8'hE1}, // R8
        {1'b1,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,8'hE1,8'hE1}  // R8
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 pout in reset", pout, 8'h00);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 pout after reset", pout, 8'h00);
        check("R1 buffer after reset", bus_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {trig_shared, bus_wr, bus_addr, bus_wdata, trig_hi, trig_lo} = VEC[i][29:17];
            @(negedge clk);
            bus_wr = 1'b0; trig_hi = 1'b0; trig_lo = 1'b0;
            bus_addr = VEC[i][16];
            #1;
            check($sformatf("row %0d pout R2-group", i), pout, VEC[i][15:8]);
            check($sformatf("row %0d rdata R2-group", i), bus_rdata, VEC[i][7:0]);
        end

        // R1: reset in mid-run clears both registers
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 pout mid-run reset", pout, 8'h00);
        trig_shared = 1'b1; bus_addr = 1'b0;
        #1;
        check("R1 buffer mid-run reset", bus_rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // R4 split read at reset value shows pad ones
        trig_shared = 1'b0;
        #1;
        check("R4 split pad after reset", bus_rdata, 8'h0F);
        bus_addr = 1'b1;
        #1;
        check("R5 split pad after reset", bus_rdata, 8'hF0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule